// File: doc/BRIEF.md
# Two-Wire Bus Timing Monitor

This block listens to the clock and data lines of an I2C-style two-wire bus without ever driving them. Both raw line samples are first cleaned by a per-line pulse filter, so that short spikes never reach the rest of the logic. The cleaned lines are then watched for bus conditions. A START (first or repeated) is a falling data line while the clock line is high, a STOP is a rising data line while the clock line is high, and a data bit is taken on each rising clock edge between a START and a STOP.

Every phase of the bus is measured in system-clock cycles by saturating counters and compared with a set of minimum durations. There is one for each of the clock low and high phases, data setup and hold around the clock edges, start hold, repeated-start setup, stop setup and bus-free time. Each kind of violation sets its own sticky flag, which stays set until a one-cycle synchronous clear. One-cycle strobes report START, STOP and each sampled data bit. The block is used inside a chip as a compliance watchdog on a bus that other logic or an external device drives.

Top module: `two_wire_timing_mon`

## Requirements
- R1: A pulse on either raw line that lasts fewer than FILT_LEN (default 3) consecutive cycles is removed and causes no strobe and no flag. A level held for FILT_LEN cycles or more passes, with the same latency on both lines.
- R2: `start_o` pulses for one cycle on each clean data fall while the clock is high, and `stop_o` on each clean data rise while the clock is high. `bit_o` pulses on each clean clock rise between a START and the following STOP, with `bit_val_o` giving the data level. At most one of the three strobes is high in any cycle.
- R3: Start hold: `err_o[0]` is set when the clock falls fewer than 14 cycles after the data fall of a START.
- R4: Clock low: `err_o[1]` is set when a clock low phase lasts fewer than 16 cycles.
- R5: Clock high: `err_o[2]` is set when a clock high phase lasts fewer than 14 cycles.
- R6: Data setup: while a transfer is open, `err_o[3]` is set when the data line last changed fewer than 20 cycles before a clock rise.
- R7: Data hold: while a transfer is open, `err_o[4]` is set when the data line changes with the clock low fewer than 8 cycles after the clock fell.
- R8: Repeated-start setup: `err_o[5]` is set when a START during an open transfer comes fewer than 14 cycles after the clock rose.
- R9: Stop setup: `err_o[6]` is set when a STOP comes fewer than 14 cycles after the clock rose.
- R10: Bus free: `err_o[7]` is set when a START from the idle bus comes fewer than 14 cycles after the previous STOP.
- R11: Flags are sticky. A bit falls only in the cycle after `clr_i` is high, and a violation found in the clear cycle itself still sets its bit.
- R12: After reset all flags are 0, no strobe is pending, and the bus is taken as idle with every phase counter saturated. A phase longer than the counter range never raises a flag.
- R13: A data change while the clock is high is always treated as a START or STOP and never as a setup or hold error. A clock rise outside an open transfer gives no `bit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all limits are counted in its periods |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_i | input | 1 | Synchronous one-cycle clear of all violation flags |
| scl_raw_i | input | 1 | Raw sample of the bus clock line |
| sda_raw_i | input | 1 | Raw sample of the bus data line |
| start_o | output | 1 | One-cycle strobe on START or repeated START |
| stop_o | output | 1 | One-cycle strobe on STOP |
| bit_o | output | 1 | One-cycle strobe on each data-bit sample |
| bit_val_o | output | 1 | Data level sampled with `bit_o` |
| err_o | output | 8 | Sticky violation flags, bit assignment as in R3 to R10 |

## Verification
On every cycle the assertions check the filter rule on both lines, meaning a clean line only moves after its raw input has held the new level for the filter length. They also check that the strobes are mutually exclusive, that flags never fall without a clear, and that a clear leaves exactly the violations of its own cycle. Whether each of the eight limits triggers at its threshold and stays quiet one cycle above it can only be shown by the bench's timed bus transfers. The same holds for the behaviour of repeated STARTs, early data changes under a high clock, and counter saturation on long phases.

// File: rtl/tbm_pkg.sv
package tbm_pkg;

  localparam int unsigned N_ERR = 8;

  // Bit positions of the violation flags
  typedef enum logic [2:0] {
    E_START_HOLD = 3'd0,
    E_CLK_LOW    = 3'd1,
    E_CLK_HIGH   = 3'd2,
    E_DAT_SETUP  = 3'd3,
    E_DAT_HOLD   = 3'd4,
    E_RSTART_SU  = 3'd5,
    E_STOP_SU    = 3'd6,
    E_BUS_FREE   = 3'd7
  } err_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tbm_deglitch.sv
module tbm_deglitch #(
  parameter int unsigned FILT_LEN = 3,
  parameter logic        RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [CW-1:0] run_q, run_d;
  logic          out_d;

  // The output follows the input only after FILT_LEN differing samples in a row
  always_comb begin
    out_d = dout;
    run_d = '0;
    if (din != dout) begin
      if (run_q == CW'(FILT_LEN - 1)) begin
        out_d = din;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      dout  <= RST_VAL;
    end else begin
      run_q <= run_d;
      dout  <= out_d;
    end
  end

endmodule

// File: rtl/tbm_span_ctr.sv
module tbm_span_ctr #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] count
);

  logic [CW-1:0] count_d;

  // Cycles since the last restart; holds at all ones instead of wrapping
  always_comb begin
    if (restart) begin
      count_d = CW'(1);
    end else if (count == '1) begin
      count_d = count;
    end else begin
      count_d = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '1;
    end else begin
      count <= count_d;
    end
  end

endmodule

// File: rtl/tbm_bus_watch.sv
module tbm_bus_watch
  import tbm_pkg::*;
#(
  parameter int unsigned START_HOLD_MIN = 14,
  parameter int unsigned CLK_LOW_MIN    = 16,
  parameter int unsigned CLK_HIGH_MIN   = 14,
  parameter int unsigned DAT_SETUP_MIN  = 20,
  parameter int unsigned DAT_HOLD_MIN   = 8,
  parameter int unsigned RSTART_SU_MIN  = 14,
  parameter int unsigned STOP_SU_MIN    = 14,
  parameter int unsigned BUS_FREE_MIN   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f,
  input  logic             sda_f,
  output logic             start_p,
  output logic             stop_p,
  output logic             bit_p,
  output logic [N_ERR-1:0] viol
);

  localparam int unsigned LIM_A = max2(max2(START_HOLD_MIN, CLK_LOW_MIN), max2(CLK_HIGH_MIN, DAT_SETUP_MIN));
  localparam int unsigned LIM_B = max2(max2(DAT_HOLD_MIN, RSTART_SU_MIN), max2(STOP_SU_MIN, BUS_FREE_MIN));
  localparam int unsigned CW    = $clog2(max2(LIM_A, LIM_B) + 1) + 1;

  logic          scl_q, sda_q;
  logic          busy_q, busy_d;
  logic          pend_q, pend_d;
  logic [CW-1:0] scl_cnt, sda_cnt;
  logic          scl_rise, scl_fall, scl_edge, sda_edge;
  logic          cond_c, data_chg;

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign scl_edge = scl_f ^ scl_q;
  assign sda_edge = sda_f ^ sda_q;
  assign cond_c   = sda_edge & scl_q & scl_f;
  assign data_chg = sda_edge & ~scl_f;

  assign start_p  = cond_c & ~sda_f;
  assign stop_p   = cond_c & sda_f;
  assign bit_p    = scl_rise & busy_q;

  // Phase length counters, one per clean line
  tbm_span_ctr #(.CW(CW)) u_scl_span (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (scl_edge),
    .count   (scl_cnt)
  );

  tbm_span_ctr #(.CW(CW)) u_sda_span (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (sda_edge),
    .count   (sda_cnt)
  );

  always_comb begin
    viol   = '0;
    busy_d = busy_q;
    pend_d = pend_q;

    if (scl_rise) begin
      if (scl_cnt < CW'(CLK_LOW_MIN)) viol[E_CLK_LOW] = 1'b1;
      if (busy_q && (sda_edge || (sda_cnt < CW'(DAT_SETUP_MIN)))) viol[E_DAT_SETUP] = 1'b1;
    end

    if (scl_fall) begin
      if (scl_cnt < CW'(CLK_HIGH_MIN)) viol[E_CLK_HIGH] = 1'b1;
      if (pend_q && (sda_cnt < CW'(START_HOLD_MIN))) viol[E_START_HOLD] = 1'b1;
      pend_d = 1'b0;
    end

    if (data_chg && busy_q) begin
      if (scl_fall || (scl_cnt < CW'(DAT_HOLD_MIN))) viol[E_DAT_HOLD] = 1'b1;
    end

    if (start_p) begin
      if (busy_q) begin
        if (scl_cnt < CW'(RSTART_SU_MIN)) viol[E_RSTART_SU] = 1'b1;
      end else begin
        if (sda_cnt < CW'(BUS_FREE_MIN)) viol[E_BUS_FREE] = 1'b1;
      end
      busy_d = 1'b1;
      pend_d = 1'b1;
    end

    if (stop_p) begin
      if (scl_cnt < CW'(STOP_SU_MIN)) viol[E_STOP_SU] = 1'b1;
      busy_d = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      scl_q  <= scl_f;
      sda_q  <= sda_f;
      busy_q <= busy_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/two_wire_timing_mon.sv
module two_wire_timing_mon
  import tbm_pkg::*;
#(
  parameter int unsigned FILT_LEN       = 3,
  parameter int unsigned START_HOLD_MIN = 14,
  parameter int unsigned CLK_LOW_MIN    = 16,
  parameter int unsigned CLK_HIGH_MIN   = 14,
  parameter int unsigned DAT_SETUP_MIN  = 20,
  parameter int unsigned DAT_HOLD_MIN   = 8,
  parameter int unsigned RSTART_SU_MIN  = 14,
  parameter int unsigned STOP_SU_MIN    = 14,
  parameter int unsigned BUS_FREE_MIN   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             scl_raw_i,
  input  logic             sda_raw_i,
  output logic             start_o,
  output logic             stop_o,
  output logic             bit_o,
  output logic             bit_val_o,
  output logic [N_ERR-1:0] err_o
);

  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw_w, clean_w;
  logic               scl_f, sda_f;
  logic               start_p, stop_p, bit_p;
  logic [N_ERR-1:0]   viol, err_d;

  assign raw_w = {sda_raw_i, scl_raw_i};

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    tbm_deglitch #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_dg (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_w[i]),
      .dout  (clean_w[i])
    );
  end

  assign scl_f = clean_w[0];
  assign sda_f = clean_w[1];

  tbm_bus_watch #(
    .START_HOLD_MIN (START_HOLD_MIN),
    .CLK_LOW_MIN    (CLK_LOW_MIN),
    .CLK_HIGH_MIN   (CLK_HIGH_MIN),
    .DAT_SETUP_MIN  (DAT_SETUP_MIN),
    .DAT_HOLD_MIN   (DAT_HOLD_MIN),
    .RSTART_SU_MIN  (RSTART_SU_MIN),
    .STOP_SU_MIN    (STOP_SU_MIN),
    .BUS_FREE_MIN   (BUS_FREE_MIN)
  ) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .start_p (start_p),
    .stop_p  (stop_p),
    .bit_p   (bit_p),
    .viol    (viol)
  );

  // New violations win over a clear in the same cycle
  always_comb begin
    err_d = (clr_i ? '0 : err_o) | viol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o   <= 1'b0;
      stop_o    <= 1'b0;
      bit_o     <= 1'b0;
      bit_val_o <= 1'b0;
      err_o     <= '0;
    end else begin
      start_o   <= start_p;
      stop_o    <= stop_p;
      bit_o     <= bit_p;
      bit_val_o <= bit_p ? sda_f : bit_val_o;
      err_o     <= err_d;
    end
  end

endmodule

// File: rtl/tbm_checker.sv
module tbm_checker
  import tbm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic             scl_raw_i,
  input logic             sda_raw_i,
  input logic             scl_f,
  input logic             sda_f,
  input logic [N_ERR-1:0] viol,
  input logic             start_o,
  input logic             stop_o,
  input logic             bit_o,
  input logic [N_ERR-1:0] err_o
);

  // R1: a clean line moves only after three matching raw samples
  a_r1_scl_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f != $past(scl_f)) |->
      ($past(scl_raw_i, 1) == scl_f && $past(scl_raw_i, 2) == scl_f && $past(scl_raw_i, 3) == scl_f));

  a_r1_sda_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_f != $past(sda_f)) |->
      ($past(sda_raw_i, 1) == sda_f && $past(sda_raw_i, 2) == sda_f && $past(sda_raw_i, 3) == sda_f));

  // R2: strobes never coincide
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, bit_o}));

  // R11: no flag falls without a clear
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_i) |-> ((err_o & $past(err_o)) == $past(err_o)));

  // R11: after a clear only the violations of the clear cycle remain
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_i) |-> (err_o == $past(viol)));

endmodule

bind two_wire_timing_mon tbm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_i     (clr_i),
  .scl_raw_i (scl_raw_i),
  .sda_raw_i (sda_raw_i),
  .scl_f     (scl_f),
  .sda_f     (sda_f),
  .viol      (viol),
  .start_o   (start_o),
  .stop_o    (stop_o),
  .bit_o     (bit_o),
  .err_o     (err_o)
);

// File: tb/two_wire_timing_mon_tb.sv
module two_wire_timing_mon_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       start_o, stop_o, bit_o, bit_val_o;
  logic [7:0] err_o;

  int n_chk = 0, n_fail = 0;
  int n_start = 0, n_stop = 0, n_bit = 0, n_bit1 = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  two_wire_timing_mon u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr),
    .scl_raw_i (scl),
    .sda_raw_i (sda),
    .start_o   (start_o),
    .stop_o    (stop_o),
    .bit_o     (bit_o),
    .bit_val_o (bit_val_o),
    .err_o     (err_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_o) n_start++;
      if (stop_o)  n_stop++;
      if (bit_o)   n_bit++;
      if (bit_o && bit_val_o) n_bit1++;
    end
  end

  typedef struct packed {
    logic [7:0] idle;
    logic [7:0] sh;
    logic [7:0] hi;
    logic [7:0] su;
    logic [7:0] hd;
    logic [7:0] ps;
    logic [7:0] mask;
  } vec_t;

  // idle, start hold, high, setup, hold, stop setup, expected flags
  localparam vec_t VEC [10] = '{
    '{8'd20, 8'd20, 8'd20, 8'd25, 8'd10, 8'd20, 8'h00},
    '{8'd10, 8'd20, 8'd20, 8'd25, 8'd10, 8'd20, 8'h80},
    '{8'd20, 8'd10, 8'd20, 8'd25, 8'd10, 8'd20, 8'h01},
    '{8'd20, 8'd20, 8'd10, 8'd25, 8'd10, 8'd20, 8'h04},
    '{8'd20, 8'd20, 8'd20, 8'd15, 8'd10, 8'd20, 8'h08},
    '{8'd20, 8'd20, 8'd20, 8'd25, 8'd4,  8'd20, 8'h10},
    '{8'd20, 8'd20, 8'd20, 8'd25, 8'd10, 8'd10, 8'h40},
    '{8'd14, 8'd14, 8'd14, 8'd20, 8'd8,  8'd14, 8'h00},
    '{8'd13, 8'd13, 8'd13, 8'd19, 8'd7,  8'd13, 8'hDD},
    '{8'd20, 8'd20, 8'd20, 8'd10, 8'd3,  8'd20, 8'h1A}
  };

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drv(input logic c, input logic d, input int n);
    scl = c;
    sda = d;
    wt(n);
  endtask

  task automatic clear_flags();
    clr = 1'b1;
    wt(1);
    clr = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    clear_flags();
    wt(20);
    // warm-up transfer with generous timing
    drv(1, 0, 20);
    drv(0, 0, 30);
    drv(1, 0, 20);
    drv(1, 1, int'(v.idle));
    // transfer under test: START, bit 1, bit 0, STOP
    drv(1, 0, int'(v.sh));
    drv(0, 0, int'(v.hd));
    drv(0, 1, int'(v.su));
    drv(1, 1, int'(v.hi));
    drv(0, 1, int'(v.hd));
    drv(0, 0, int'(v.su));
    drv(1, 0, int'(v.ps));
    drv(1, 1, 8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      report();
    end
  end

  initial begin
    int s0, p0, b0, b10;
    wt(5);
    rst_n = 1'b1;
    wt(20);
    // R12: reset state
    chk(err_o == 8'h00, "R12 reset flags", int'(err_o), 0);
    chk(n_start == 0 && n_stop == 0 && n_bit == 0, "R12 reset strobes", n_start + n_stop + n_bit, 0);

    // Table of timed transfers: R3..R10 at and around each limit
    for (int i = 0; i < 10; i++) begin
      s0 = n_start; p0 = n_stop; b0 = n_bit; b10 = n_bit1;
      run_vec(VEC[i]);
      chk(err_o == VEC[i].mask, $sformatf("R3-flags vec%0d (R3 R4 R5 R6 R7 R9 R10)", i),
          int'(err_o), int'(VEC[i].mask));
      chk(n_start - s0 == 2 && n_stop - p0 == 2 && n_bit - b0 == 3 && n_bit1 - b10 == 1,
          $sformatf("R2 strobes vec%0d", i),
          (n_start - s0) * 256 + (n_stop - p0) * 16 + (n_bit - b0), 2 * 256 + 2 * 16 + 3);
    end

    // R1: 2-cycle SDA spike while idle is dropped
    clear_flags(); wt(30);
    s0 = n_start; p0 = n_stop;
    drv(1, 0, 2); drv(1, 1, 30);
    chk(n_start == s0 && n_stop == p0, "R1 short sda spike", n_start - s0, 0);
    // R1: 3-cycle pulse passes as START then STOP
    drv(1, 0, 3); drv(1, 1, 30);
    chk(n_start == s0 + 1 && n_stop == p0 + 1, "R1 3-cycle pulse", n_start - s0, 1);

    // R1: SCL spike inside a low phase creates no bit and no low-phase error
    clear_flags(); wt(30);
    b0 = n_bit;
    drv(1, 0, 20); drv(0, 0, 10); drv(1, 0, 2); drv(0, 0, 20);
    drv(0, 1, 25); drv(1, 1, 20); drv(0, 1, 10); drv(0, 0, 25);
    drv(1, 0, 20); drv(1, 1, 30);
    chk(err_o == 8'h00, "R1 scl spike flags", int'(err_o), 0);
    chk(n_bit - b0 == 2, "R1 scl spike bits", n_bit - b0, 2);

    // R8: repeated START with enough setup
    clear_flags(); wt(30);
    s0 = n_start; b0 = n_bit;
    drv(1, 0, 20); drv(0, 0, 10); drv(0, 1, 25); drv(1, 1, 20);
    drv(1, 0, 20); drv(0, 0, 30); drv(1, 0, 20); drv(1, 1, 30);
    chk(err_o == 8'h00, "R8 repeated start ok", int'(err_o), 0);
    chk(n_start - s0 == 2 && n_bit - b0 == 2, "R8 repeated start strobes", n_start - s0, 2);
    // R8: repeated START too soon after clock rise
    clear_flags(); wt(30);
    drv(1, 0, 20); drv(0, 0, 10); drv(0, 1, 25); drv(1, 1, 10);
    drv(1, 0, 20); drv(0, 0, 30); drv(1, 0, 20); drv(1, 1, 30);
    chk(err_o == 8'h20, "R8 repeated start setup", int'(err_o), 8'h20);

    // R11: flags stay set and a single clear drops them
    wt(100);
    chk(err_o == 8'h20, "R11 sticky", int'(err_o), 8'h20);
    clear_flags(); wt(2);
    chk(err_o == 8'h00, "R11 clear", int'(err_o), 0);

    // R12: a 70-cycle low phase saturates the counter and raises nothing
    drv(1, 0, 20); drv(0, 0, 10); drv(0, 1, 60); drv(1, 1, 20);
    drv(0, 1, 10); drv(0, 0, 25); drv(1, 0, 20); drv(1, 1, 30);
    chk(err_o == 8'h00, "R12 saturation", int'(err_o), 0);

    // R13: data rise under a high clock is a STOP; later clock pulse gives no bit
    clear_flags(); wt(30);
    p0 = n_stop; b0 = n_bit;
    drv(1, 0, 20); drv(0, 0, 30); drv(1, 0, 20); drv(1, 1, 20);
    drv(0, 1, 30); drv(1, 1, 30);
    chk(n_stop - p0 == 1, "R13 early change is STOP", n_stop - p0, 1);
    chk((err_o & 8'h18) == 8'h00, "R13 no setup/hold error", int'(err_o), 0);
    chk(n_bit - b0 == 1, "R13 no bit outside transfer", n_bit - b0, 1);

    done = 1'b1;
    report();
  end

endmodule